// File: doc/BRIEF.md
# JTAG Chain Length Probe

This block drives a JTAG port on its own and finds out how many TAP controllers sit in series between its TDI output and its TDO input. A single start pulse begins the run. The block first walks every controller into the instruction-shift state. It then fills all instruction registers with ones, so that each device selects its one-bit bypass register. Next it moves to the data-shift state and clears the bypass path with zeros. Last, it feeds ones in one at a time and counts them until the first one comes back on TDO.

When the run ends, the block leaves the chain in Test-Logic-Reset and raises a one-cycle done pulse. If no one comes back within the programmed flush length, it reports a timeout and a count of zero. The flush length sets both the number of ones in the instruction flood and the number of zeros in the bypass flush, so it must exceed the total instruction-register length of the chain. The TCK rate is set by a divider on the system clock.

Top module: `jtag_chain_counter`

## Requirements
- R1: After reset and while idle: busy, done and timeout are 0, tap_count is 0, tck is 0 and tms is 1.
- R2: After start, the TMS values sampled at the first ten rising TCK edges are 1,1,1,1,1 (forced reset) and then 0,1,1,0,0 (move into Shift-IR).
- R3: The next flush_len bits carry TDI=1, with TMS=0 on every bit except the last, which has TMS=1. The four bits after them carry TMS=1,1,0,0 to reach Shift-DR through Update-IR.
- R4: Next come flush_len bits with TDI=0 and TMS=0, followed by bits with TDI=1 and TMS=0. TDO is sampled on each rising TCK. tap_count equals the number of counting bits issued before the bit in which TDO reads 1. A chain with no devices gives 0.
- R5: If TDO is not 1 within flush_len counting bits, timeout is set and tap_count is 0.
- R6: After the count phase, five bits with TMS=1 are issued. Then done pulses high for exactly one clock with busy low, and the chain is in Test-Logic-Reset.
- R7: Each TCK half period lasts clk_div+1 system clocks. TMS and TDI change only while TCK is low.
- R8: A start pulse during a run is ignored: the run gives one done pulse and the correct count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| flush_len | input | 16 | Bits per flood, flush and count limit |
| clk_div | input | 8 | TCK half period minus one, in clocks |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | No one returned in the last run |
| tap_count | output | 16 | Number of TAPs found |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to chain |
| tdo | input | 1 | JTAG data from chain |

## Verification
The in-module assertions check on every cycle that:
- TMS and TDI stay steady while TCK is high.
- The port is parked with TCK low and TMS high when idle.
- done is a single-cycle pulse that never coincides with busy.
- A timeout always comes with a zero count.

Only the bench scenarios can show the rest. They use a behavioural chain of TAP models to confirm the exact TMS and TDI bit streams, the counts for chains of 0, 1, 3 and 8 devices, the timeout on a dead TDO, the TCK period for a given divider, that a second start is ignored, and that every device ends in Test-Logic-Reset.

// File: rtl/jtag_chain_counter.sv
module jtag_chain_counter #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] flush_len,
  input  logic [DW-1:0] clk_div,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [CW-1:0] tap_count,
  output logic          tck,
  output logic          tms,
  output logic          tdi,
  input  logic          tdo
);
  typedef enum logic [2:0] {S_IDLE, S_RST, S_TOIR, S_IRF, S_TODR, S_DRZ, S_CNT, S_EXIT} st_t;
  localparam logic [4:0] TOIR_PAT = 5'b00110;
  localparam logic [3:0] TODR_PAT = 4'b0011;

  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div;
  logic hit;
  logic [CW-1:0] last;
  logic tick;

  assign busy = (st != S_IDLE);
  assign last = (flush_len == '0) ? '0 : flush_len - 1'b1;
  assign tick = busy && (div == clk_div);

  always_comb begin
    tms = 1'b0;
    tdi = 1'b0;
    case (st)
      S_IDLE, S_RST, S_EXIT: tms = 1'b1;
      S_TOIR: tms = TOIR_PAT[cnt[2:0]];
      S_IRF:  begin tdi = 1'b1; tms = (cnt == last); end
      S_TODR: tms = TODR_PAT[cnt[1:0]];
      S_CNT:  tdi = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; div <= '0; tck <= 1'b0; hit <= 1'b0;
      done <= 1'b0; timeout <= 1'b0; tap_count <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_RST; cnt <= '0; div <= '0; tck <= 1'b0; hit <= 1'b0;
          timeout <= 1'b0; tap_count <= '0;
        end
      end else if (tick) begin
        div <= '0;
        if (!tck) begin
          tck <= 1'b1;
          hit <= tdo;
        end else begin
          tck <= 1'b0;
          cnt <= cnt + 1'b1;
          case (st)
            S_RST:  if (cnt == 4) begin st <= S_TOIR; cnt <= '0; end
            S_TOIR: if (cnt == 4) begin st <= S_IRF; cnt <= '0; end
            S_IRF:  if (cnt == last) begin st <= S_TODR; cnt <= '0; end
            S_TODR: if (cnt == 3) begin st <= S_DRZ; cnt <= '0; end
            S_DRZ:  if (cnt == last) begin st <= S_CNT; cnt <= '0; end
            S_CNT: begin
              if (hit) begin
                tap_count <= cnt; st <= S_EXIT; cnt <= '0;
              end else if (cnt == last) begin
                timeout <= 1'b1; st <= S_EXIT; cnt <= '0;
              end
            end
            S_EXIT: if (cnt == 4) begin st <= S_IDLE; cnt <= '0; done <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));
  a_r1_idle_park: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tck && tms));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (tap_count == '0));
endmodule

// File: tb/jtag_chain_counter_test.sv
module tap_model (
  input  logic rst,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic [3:0] state
);
  localparam logic [3:0] TLR=0, RTI=1, SDS=2, CDR=3, SDR=4, E1D=5, PDR=6, E2D=7,
                         UDR=8, SIS=9, CIR=10, SIR=11, E1I=12, PIR=13, E2I=14, UIR=15;
  logic [3:0] ir, irsr;
  logic byp;
  logic [31:0] idsr;
  logic [3:0] nx;
  always_comb begin
    case (state)
      TLR: nx = tms ? TLR : RTI;
      RTI: nx = tms ? SDS : RTI;
      SDS: nx = tms ? SIS : CDR;
      CDR: nx = tms ? E1D : SDR;
      SDR: nx = tms ? E1D : SDR;
      E1D: nx = tms ? UDR : PDR;
      PDR: nx = tms ? E2D : PDR;
      E2D: nx = tms ? UDR : SDR;
      UDR: nx = tms ? SDS : RTI;
      SIS: nx = tms ? TLR : CIR;
      CIR: nx = tms ? E1I : SIR;
      SIR: nx = tms ? E1I : SIR;
      E1I: nx = tms ? UIR : PIR;
      PIR: nx = tms ? E2I : PIR;
      E2I: nx = tms ? UIR : SIR;
      default: nx = tms ? SDS : RTI;
    endcase
  end
  always @(posedge tck or posedge rst) begin
    if (rst) begin
      state <= TLR; ir <= 4'b0001; irsr <= 4'b0; byp <= 1'b0; idsr <= 32'h0;
    end else begin
      case (state)
        TLR: ir <= 4'b0001;
        CIR: irsr <= 4'b0001;
        SIR: irsr <= {tdi, irsr[3:1]};
        UIR: ir <= irsr;
        CDR: begin byp <= 1'b0; idsr <= 32'h0BA0_0477; end
        SDR: if (ir == 4'hF) byp <= tdi; else idsr <= {tdi, idsr[31:1]};
        default: ;
      endcase
      state <= nx;
    end
  end
  always @(negedge tck or posedge rst) begin
    if (rst) tdo <= 1'b0;
    else if (state == SIR) tdo <= irsr[0];
    else if (state == SDR) tdo <= (ir == 4'hF) ? byp : idsr[0];
  end
endmodule

module jtag_chain_counter_test;
  localparam int MAXN = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] flush_len = 16'd64;
  logic [7:0] clk_div = 8'd0;
  logic busy, done, timeout, tck, tms, tdi, tdo;
  logic [15:0] tap_count;
  logic [MAXN-1:0] tdo_arr;
  logic [3:0] st_arr [MAXN];
  int chain_n = 1;
  logic dead = 1'b0;
  int checks = 0, fails = 0, dones = 0;
  logic lg_tms [1024];
  logic lg_tdi [1024];
  int lg_n = 0;

  always #10 clk = ~clk;

  jtag_chain_counter uut (.clk(clk), .rst_n(rst_n), .start(start), .flush_len(flush_len),
    .clk_div(clk_div), .busy(busy), .done(done), .timeout(timeout), .tap_count(tap_count),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

  for (genvar g = 0; g < MAXN; g++) begin : g_tap
    tap_model m (.rst(!rst_n), .tck(tck), .tms(tms),
      .tdi(g == 0 ? tdi : tdo_arr[(g == 0) ? 0 : g-1]), .tdo(tdo_arr[g]), .state(st_arr[g]));
  end

  assign tdo = dead ? 1'b0 : (chain_n == 0 ? tdi : tdo_arr[chain_n-1]);

  always @(posedge tck) if (lg_n < 1024) begin
    lg_tms[lg_n] = tms; lg_tdi[lg_n] = tdi; lg_n = lg_n + 1;
  end
  always @(posedge clk) if (done) dones = dones + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int l, input int d);
    chain_n = n; flush_len = 16'(l); clk_div = 8'(d);
    @(negedge clk); lg_n = 0; dones = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 timeout", timeout, 0);
    chk("R1 count", tap_count, 0); chk("R1 tck", tck, 0); chk("R1 tms", tms, 1);
  endtask

  task automatic t_stream(input int n, input int l);
    logic ok2, ok3, ok4;
    logic [9:0] pre;
    run(n, l, 0);
    ok2 = 1; ok3 = 1; ok4 = 1;
    pre = 10'b0011011111;
    for (int i = 0; i < 10; i++) if (lg_tms[i] !== pre[i]) ok2 = 0;
    chk("R2 tms prefix", ok2, 1);
    for (int i = 0; i < l; i++) begin
      if (lg_tdi[10+i] !== 1'b1) ok3 = 0;
      if (lg_tms[10+i] !== (i == l-1)) ok3 = 0;
    end
    if (lg_tms[10+l] !== 1 || lg_tms[11+l] !== 1 || lg_tms[12+l] !== 0 || lg_tms[13+l] !== 0) ok3 = 0;
    chk("R3 IR flood and exit", ok3, 1);
    for (int i = 0; i < l; i++)
      if (lg_tdi[14+l+i] !== 1'b0 || lg_tms[14+l+i] !== 1'b0) ok4 = 0;
    chk("R4 zero flush", ok4, 1);
    chk("R4 count", tap_count, n);
    chk("R6 total bits", lg_n, 14 + 2*l + n + 1 + 5);
  endtask

  task automatic t_count(input int n, input int l);
    run(n, l, 0);
    chk("R4 count", tap_count, n);
    chk("R5 no timeout", timeout, 0);
    chk("R6 busy low at done", busy, 0);
    for (int i = 0; i < MAXN; i++) chk("R6 chain in TLR", st_arr[i], 0);
    @(negedge clk); chk("R6 done one cycle", done, 0);
  endtask

  task automatic t_timeout;
    dead = 1'b1;
    run(3, 16, 0);
    chk("R5 timeout", timeout, 1);
    chk("R5 count zero", tap_count, 0);
    dead = 1'b0;
  endtask

  task automatic t_period;
    time t0, t1;
    chain_n = 2; flush_len = 16'd32; clk_div = 8'd2;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    @(posedge tck); t0 = $time;
    @(posedge tck); t1 = $time;
    chk("R7 tck period ns", 32'(t1 - t0), 120);
    do @(negedge clk); while (!done);
    chk("R7 count with divider", tap_count, 2);
  endtask

  task automatic t_restart;
    chain_n = 5; flush_len = 16'd48; clk_div = 8'd1;
    @(negedge clk); dones = 0; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    do @(negedge clk); while (!done);
    repeat (20) @(negedge clk);
    chk("R8 single done", dones, 1);
    chk("R8 count", tap_count, 5);
    chk("R8 idle after", busy, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream(3, 40);
    t_count(1, 64);
    t_count(8, 64);
    t_count(0, 16);
    t_timeout();
    t_period();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule